// File: doc/BRIEF.md
# Cartridge Real-Time Clock with Latched Read Registers

This block keeps wall-clock time for a game cartridge: seconds, minutes, hours and a 9-bit day count, advanced by a prescaled tick strobe that arrives `TICKS_PER_SEC` times per second. The counters run all the time. Software does not read them directly. It reads a frozen copy that is refreshed only when it performs a two-step latch handshake, so a multi-byte read can never straddle a rollover.

The bank controller around the block decodes the bus. It presents a one-byte register select code, a write strobe with data, and a separate strobe with data for the latch handshake. Writes go to the running counters, which lets software set the time, stop the clock with a halt flag, and clear a sticky flag that records a day-count overflow.

Top module: `rtc_latch_clock`

## Requirements
- R1: After reset, every readable register (codes 0x08 to 0x0C) reads 0x00, the running time is zero, halt and carry are clear and the latch is not armed.
- R2: `rdData` is combinational from the latched copy. Code 0x08 gives seconds, 0x09 minutes, 0x0A hours and 0x0B day bits 7:0. Code 0x0C gives day bit 8 in bit 0, halt in bit 6, carry in bit 7 and zeros elsewhere. Any other code reads 0xFF.
- R3: A register write keeps only the valid bits: 6 bits for seconds and minutes, 5 bits for hours, and the full byte into day bits 7:0. A write to code 0x0C takes bit 0 as day bit 8, bit 6 as halt and bit 7 as carry.
- R4: A latch-strobe write of 0x00 arms the latch when it is not armed. A following latch-strobe write of 0x01 copies all live fields into the readable copy on that clock edge and disarms. Until that happens, reads keep the older copy.
- R5: Every other latch-strobe write disarms without copying. This includes 0x01 when not armed, 0x00 when already armed, and any other value.
- R6: On each second, seconds count up. Seconds wrap 59 to 0 and carry into minutes. Minutes wrap 59 to 0 and carry into hours. Hours wrap 23 to 0 and carry into the day count.
- R7: When the day count wraps from 511 to 0, the carry flag sets. It stays set through further counting until a write to code 0x0C clears bit 7.
- R8: While halt is set, ticks are ignored. The time and the sub-second phase hold.
- R9: One second passes every `TICKS_PER_SEC` ticks. A write to seconds restarts that sub-second phase at zero.
- R10: A tick arriving in the same cycle as any register write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle tick strobe, `TICKS_PER_SEC` per second |
| regSel | input | 8 | Register select code for reads and writes |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Read data from the latched copy |
| latchWr | input | 1 | Latch handshake write strobe |
| latchData | input | 8 | Latch handshake write data |

## Verification
Every byte value is written to each time field and read back, which separates correct masking from a wrong field width. A long run of ticks from zero is compared against seconds, minutes, hours and days computed arithmetically from the elapsed tick count. A second run starts just below the last second of day 511 and checks each second through the hour, day and overflow carry. Short targeted sequences cover the rest: latch handshakes in their armed and disarmed orders, halt, a mid-second seconds write, and a tick colliding with a write. Each sequence is built so that a counted tick or a wrong latch would leave a different value in the read copy.

// File: rtl/rtc_latch_pkg.sv
package rtc_latch_pkg;
  localparam logic [7:0] SEL_SEC   = 8'h08;
  localparam logic [7:0] SEL_MIN   = 8'h09;
  localparam logic [7:0] SEL_HOUR  = 8'h0A;
  localparam logic [7:0] SEL_DAYLO = 8'h0B;
  localparam logic [7:0] SEL_DAYHI = 8'h0C;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic wrSec;
    logic wrMin;
    logic wrHour;
    logic wrDayLo;
    logic wrDayHi;
    logic advance;   // one full second elapsed
    logic doLatch;   // copy live time into read copy
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_latch_ctrl.sv
module rtc_latch_ctrl
  import rtc_latch_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       wrEn,
  input  logic [7:0] regSel,
  input  logic       latchWr,
  input  logic [7:0] latchData,
  input  logic       haltLive,
  output rtcStrobe_t strb
);
  localparam int PH_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_SEC - 1);

  logic [PH_W-1:0] phase;
  logic            armed;
  logic            tickEff;

  // a tick counts only when running and not colliding with a write
  assign tickEff = tickIn && !haltLive && !wrEn;

  always_comb begin
    strb.wrSec   = wrEn && (regSel == SEL_SEC);
    strb.wrMin   = wrEn && (regSel == SEL_MIN);
    strb.wrHour  = wrEn && (regSel == SEL_HOUR);
    strb.wrDayLo = wrEn && (regSel == SEL_DAYLO);
    strb.wrDayHi = wrEn && (regSel == SEL_DAYHI);
    strb.advance = tickEff && (phase == PH_LAST);
    strb.doLatch = latchWr && armed && (latchData == 8'h01);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
      armed <= 1'b0;
    end else begin
      if (strb.wrSec)
        phase <= '0;
      else if (tickEff)
        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      if (latchWr)
        armed <= (latchData == 8'h00) && !armed;
    end
  end

  p_phase_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSec |=> (phase == '0));
  p_halt_phase_r8: assert property (@(posedge clk) disable iff (!rstN)
    (haltLive && !strb.wrSec) |=> $stable(phase));
  p_disarm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (latchWr && latchData != 8'h00) |=> !armed);
  p_arm_r4: assert property (@(posedge clk) disable iff (!rstN)
    (latchWr && latchData == 8'h00 && !armed) |=> armed);
endmodule

// File: rtl/rtc_latch_dp.sv
module rtc_latch_dp
  import rtc_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rtcStrobe_t strb,
  input  logic [7:0] wrData,
  input  logic [7:0] regSel,
  output logic [7:0] rdData,
  output logic       haltLive
);
  logic [5:0] secL, minL, latSec, latMin;
  logic [4:0] hourL, latHour;
  logic [8:0] dayL, latDay;
  logic       haltL, carryL, latHalt, latCarry;
  logic       secWrap, minWrap, hourWrap, minStep, hourStep, dayStep;

  assign secWrap  = (secL == 6'd59);
  assign minWrap  = (minL == 6'd59);
  assign hourWrap = (hourL == 5'd23);
  assign minStep  = strb.advance && secWrap;
  assign hourStep = minStep && minWrap;
  assign dayStep  = hourStep && hourWrap;
  assign haltLive = haltL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secL <= '0; minL <= '0; hourL <= '0; dayL <= '0;
      haltL <= 1'b0; carryL <= 1'b0;
    end else begin
      if (strb.wrSec)        secL <= wrData[5:0];
      else if (strb.advance) secL <= secWrap ? 6'd0 : secL + 6'd1;

      if (strb.wrMin)        minL <= wrData[5:0];
      else if (minStep)      minL <= minWrap ? 6'd0 : minL + 6'd1;

      if (strb.wrHour)       hourL <= wrData[4:0];
      else if (hourStep)     hourL <= hourWrap ? 5'd0 : hourL + 5'd1;

      if (strb.wrDayLo)      dayL <= {dayL[8], wrData};
      else if (strb.wrDayHi) dayL <= {wrData[0], dayL[7:0]};
      else if (dayStep)      dayL <= dayL + 9'd1;

      if (strb.wrDayHi) begin
        haltL  <= wrData[6];
        carryL <= wrData[7];
      end else if (dayStep && dayL == 9'd511) begin
        carryL <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latSec <= '0; latMin <= '0; latHour <= '0; latDay <= '0;
      latHalt <= 1'b0; latCarry <= 1'b0;
    end else if (strb.doLatch) begin
      latSec <= secL; latMin <= minL; latHour <= hourL; latDay <= dayL;
      latHalt <= haltL; latCarry <= carryL;
    end
  end

  always_comb begin
    case (regSel)
      SEL_SEC:   rdData = {2'b00, latSec};
      SEL_MIN:   rdData = {2'b00, latMin};
      SEL_HOUR:  rdData = {3'b000, latHour};
      SEL_DAYLO: rdData = latDay[7:0];
      SEL_DAYHI: rdData = {latCarry, latHalt, 5'b00000, latDay[8]};
      default:   rdData = 8'hFF;
    endcase
  end

  p_sec_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && secL == 6'd59) |=> (secL == 6'd0));
  p_carry_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (carryL && !strb.wrDayHi) |=> carryL);
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (haltL && !strb.wrSec) |=> $stable(secL));
  p_latch_copy_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.doLatch |=> (latSec == $past(secL) && latDay == $past(dayL)));
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doLatch |=> $stable(latSec));
endmodule

// File: rtl/rtc_latch_clock.sv
module rtc_latch_clock
  import rtc_latch_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic [7:0] regSel,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       latchWr,
  input  logic [7:0] latchData
);
  rtcStrobe_t strb;
  logic       haltLive;

  rtc_latch_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn), .regSel(regSel),
    .latchWr(latchWr), .latchData(latchData), .haltLive(haltLive), .strb(strb)
  );

  rtc_latch_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .regSel(regSel),
    .rdData(rdData), .haltLive(haltLive)
  );
endmodule

// File: tb/rtc_latch_clock_tb_top.sv
module rtc_latch_clock_tb_top;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic [7:0] regSel = 8'h00;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       latchWr = 1'b0;
  logic [7:0] latchData = 8'h00;

  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  rtc_latch_clock #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .latchWr(latchWr), .latchData(latchData)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, got, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] code, input logic [7:0] val, input logic withTick = 1'b0);
    @(negedge clk);
    regSel = code; wrData = val; wrEn = 1'b1; tickIn = withTick;
    @(negedge clk);
    wrEn = 1'b0; tickIn = 1'b0;
  endtask

  task automatic latchW(input logic [7:0] val);
    @(negedge clk);
    latchData = val; latchWr = 1'b1;
    @(negedge clk);
    latchWr = 1'b0;
  endtask

  task automatic doLatch();
    latchW(8'h00);
    latchW(8'h01);
  endtask

  task automatic rdReg(input logic [7:0] code, output logic [7:0] val);
    @(negedge clk);
    regSel = code;
    #1 val = rdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickIn = 1'b1;
      @(negedge clk); tickIn = 1'b0;
    end
  endtask

  task automatic chkTime(input string req, input longint t, input logic halt);
    logic [7:0] v;
    longint days;
    days = t / 86400;
    rdReg(8'h08, v); chk(req, v, 8'(t % 60));
    rdReg(8'h09, v); chk(req, v, 8'((t / 60) % 60));
    rdReg(8'h0A, v); chk(req, v, 8'((t / 3600) % 24));
    rdReg(8'h0B, v); chk(req, v, 8'(days % 256));
    rdReg(8'h0C, v);
    chk(req, v, {(days >= 512), halt, 5'b0, 1'((days % 512) / 256)});
  endtask

  task automatic setTime(input longint t);
    longint days;
    days = t / 86400;
    wrReg(8'h08, 8'(t % 60));
    wrReg(8'h09, 8'(((t / 60) % 60)));
    wrReg(8'h0A, 8'((t / 3600) % 24));
    wrReg(8'h0B, 8'(days % 256));
    wrReg(8'h0C, {7'b0, 1'(days / 256)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    longint t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of all readable registers
    for (int c = 8; c <= 12; c++) begin
      rdReg(8'(c), v); chk("R1", v, 8'h00);
    end
    // R2: unused codes read 0xFF
    rdReg(8'h07, v); chk("R2", v, 8'hFF);
    rdReg(8'h0D, v); chk("R2", v, 8'hFF);
    rdReg(8'h00, v); chk("R2", v, 8'hFF);

    // R3: masking sweep over every byte value
    for (int x = 0; x < 256; x++) begin
      wrReg(8'h08, 8'(x)); wrReg(8'h09, 8'(x ^ 8'h5A));
      wrReg(8'h0A, 8'(x)); wrReg(8'h0B, 8'(x ^ 8'hC3));
      doLatch();
      rdReg(8'h08, v); chk("R3 sec", v, 8'(x) & 8'h3F);
      rdReg(8'h09, v); chk("R3 min", v, 8'(x ^ 8'h5A) & 8'h3F);
      rdReg(8'h0A, v); chk("R3 hour", v, 8'(x) & 8'h1F);
      rdReg(8'h0B, v); chk("R3 daylo", v, 8'(x ^ 8'hC3));
    end
    // R2 and R3: day-high packing (halt on stops ticks, none issued here)
    wrReg(8'h0C, 8'hFF); doLatch();
    rdReg(8'h0C, v); chk("R2 dayhi pack", v, 8'hC1);
    wrReg(8'h0C, 8'h00); doLatch();
    rdReg(8'h0C, v); chk("R2 dayhi clear", v, 8'h00);

    // R4: reads hold the old copy until the handshake completes
    wrReg(8'h08, 8'd5); doLatch();
    wrReg(8'h08, 8'd9);
    rdReg(8'h08, v); chk("R4 hold", v, 8'd5);
    latchW(8'h00);
    rdReg(8'h08, v); chk("R4 armed only", v, 8'd5);
    latchW(8'h01);
    rdReg(8'h08, v); chk("R4 latched", v, 8'd9);

    // R5: sequences that must not latch
    wrReg(8'h08, 8'd17);
    latchW(8'h01);
    rdReg(8'h08, v); chk("R5 unarmed 01", v, 8'd9);
    latchW(8'h00); latchW(8'h00); latchW(8'h01);
    rdReg(8'h08, v); chk("R5 double 00", v, 8'd9);
    latchW(8'h00); latchW(8'h02); latchW(8'h01);
    rdReg(8'h08, v); chk("R5 other value", v, 8'd9);
    latchW(8'h00); latchW(8'h01); latchW(8'h01);
    rdReg(8'h08, v); chk("R5 then latch", v, 8'd17);

    // R6 and R9: long count from zero, seconds every TPS ticks
    setTime(0);
    for (int s = 1; s <= 3700; s++) begin
      ticks(TPS);
      if (s % 123 == 0 || s == 3700) begin
        doLatch(); chkTime("R6 count", longint'(s), 1'b0);
      end
    end

    // R6 and R7: roll through hour, day and day-count overflow
    t0 = 511 * 86400 + 23 * 3600 + 59 * 60 + 50;
    setTime(t0);
    for (int k = 1; k <= 20; k++) begin
      ticks(TPS);
      doLatch(); chkTime("R7 wrap", t0 + k, 1'b0);
    end
    // R7: carry stays set, clears only by writing bit 7 low
    ticks(TPS * 3); doLatch();
    rdReg(8'h0C, v); chk("R7 sticky", v, 8'h80);
    wrReg(8'h0C, 8'h01); doLatch();
    rdReg(8'h0C, v); chk("R7 cleared", v, 8'h01);

    // R8: halt freezes time and phase
    setTime(100);
    ticks(2);
    wrReg(8'h0C, 8'h40);
    ticks(TPS * 3);
    doLatch(); chkTime("R8 halted", 100, 1'b1);
    wrReg(8'h0C, 8'h00);
    ticks(TPS - 2);
    doLatch(); chkTime("R8 resume phase", 101, 1'b0);

    // R9: seconds write resets the phase
    wrReg(8'h08, 8'd0);
    ticks(TPS - 1);
    wrReg(8'h08, 8'd0);
    ticks(TPS - 1);
    doLatch();
    rdReg(8'h08, v); chk("R9 phase cleared", v, 8'd0);
    ticks(1); doLatch();
    rdReg(8'h08, v); chk("R9 second", v, 8'd1);

    // R10: tick colliding with a write is dropped
    wrReg(8'h08, 8'd30);
    ticks(TPS - 1);
    wrReg(8'h09, 8'd7, 1'b1);
    doLatch();
    rdReg(8'h08, v); chk("R10 dropped", v, 8'd30);
    rdReg(8'h09, v); chk("R10 write", v, 8'd7);
    ticks(1); doLatch();
    rdReg(8'h08, v); chk("R10 next tick", v, 8'd31);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule